// File: doc/BRIEF.md
# Keyed Fractional Bit-Clock Divider

This block produces the bit clock of an audio serial port by dividing one of several source clocks. Software controls it through two 32-bit registers: a control word (source choice, enable, stop, polarity, shaping order) and a divisor word (integer and fractional parts). A register write is only taken when its top byte carries the key value 0x5A, so stray bus traffic cannot retune or halt the clock. All logic runs on a single fast system clock. Each source is a per-cycle enable pulse (`osc_tick`, `pll_tick`), and one output period spans a programmed number of pulses of the chosen source.

In integer mode every period lasts exactly the integer divisor. In first-order shaped mode a 12-bit error accumulator adds the fraction once per period and stretches the period by one pulse on every carry, so the average ratio is the integer plus the fraction over 4096. Clearing the enable bit gives a clean stop: busy stays set until the output is in its low phase. The kill bit stops the generator at once.

Top module: `keyed_frac_clkdiv`

## Requirements
- R1: A write (`wr_en` high) is accepted only when `wr_data[31:24]` is 0x5A. Any other key leaves both registers unchanged. `wr_sel` = 0 selects the control word and `wr_sel` = 1 selects the divisor word.
- R2: The control word reads back with order in bits 10:9, flip in bit 8, busy in bit 7, kill in bit 5, enable in bit 4 and source in bits 3:0. All other bits read as zero. Busy is read-only, so writes to bit 7 are dropped.
- R3: The divisor word holds the integer part in bits 23:12 and the fraction in bits 11:0. Bits 31:24 read as zero. An integer part of 0 or 1 divides as 2.
- R4: Source code 1 counts `osc_tick` pulses and code 6 counts `pll_tick` pulses. Every other code supplies no pulses, and a running output then holds its level.
- R5: Two edges after a write that sets enable, busy rises and the output starts its high phase. A period of P pulses is high for the first floor(P/2) pulses and low for the rest. With order 0, P is the effective integer divisor.
- R6: With a nonzero order, the 12-bit accumulator starts at the fraction. At each period end it adds the fraction; a carry makes the next period integer+1 pulses, otherwise it is the integer.
- R7: A divisor written while running is first used by the period that starts after the write has landed. A write landing on the same edge as a period end does not affect the period started at that edge.
- R8: After enable is cleared, busy stays high and the output keeps running until the output is in its low phase. Busy then drops on the next edge and the output stays idle.
- R9: While kill is set, the generator is idle from the next edge (busy low, output idle, accumulator cleared), whatever state it was in, and enable is ignored.
- R10: The output equals the raw divided clock XOR the flip bit. When idle, it equals flip.
- R11: After reset both registers read zero, busy is low and the output is low.
- R12: Order values 2 and 3 behave exactly like order 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: control word, 1: divisor word |
| wr_data | input | 32 | Write data, top byte is the key |
| osc_tick | input | 1 | Oscillator source pulse (code 1) |
| pll_tick | input | 1 | Fast PLL source pulse (code 6) |
| clk_out | output | 1 | Divided bit clock |
| ctrl_rdata | output | 32 | Control word readback including busy |
| div_rdata | output | 32 | Divisor word readback |

## Verification
Two things can land on the same edge. A register write can land on the edge where a period ends, and the generator then latches its next length. Kill or a cleared enable can also arrive on the edge where a period wraps. The bench provokes both by rewriting the divisor and pulsing kill at varied intervals, against a pseudo-random pulse train and a pulse on every cycle, so that writes fall on wrap edges among others. A behavioural model that latches the period length from the pre-write divisor is compared with the output, busy and readbacks on every cycle. Any disagreement over which divisor a period used shows up as a shifted edge.

// File: rtl/kfcd_pkg.sv
package kfcd_pkg;
    localparam int WORD_W = 32;
    localparam int KEY_W  = 8;
    localparam logic [KEY_W-1:0] WR_KEY = 8'h5A;
    localparam int INT_W  = 12;
    localparam int FRAC_W = 12;
    localparam int SRC_W  = 4;
    localparam int ORD_W  = 2;
    localparam int PER_W  = INT_W + 1;
    localparam logic [SRC_W-1:0] SRC_CODE_OSC = 4'd1;
    localparam logic [SRC_W-1:0] SRC_CODE_PLL = 4'd6;

    typedef enum logic {GEN_IDLE = 1'b0, GEN_RUN = 1'b1} gen_state_e;

    typedef struct packed {
        logic [ORD_W-1:0] order;
        logic             flip;
        logic             kill;
        logic             en;
        logic [SRC_W-1:0] src;
    } ctrl_t;

    typedef struct packed {
        logic [INT_W-1:0]  ipart;
        logic [FRAC_W-1:0] fpart;
    } divs_t;

    function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.order = w[10:9];
        c.flip  = w[8];
        c.kill  = w[5];
        c.en    = w[4];
        c.src   = w[3:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c, input logic busy);
        logic [WORD_W-1:0] w;
        w       = '0;
        w[10:9] = c.order;
        w[8]    = c.flip;
        w[7]    = busy;
        w[5]    = c.kill;
        w[4]    = c.en;
        w[3:0]  = c.src;
        return w;
    endfunction

    function automatic logic [PER_W-1:0] eff_int(input logic [INT_W-1:0] n);
        return (n < INT_W'(2)) ? PER_W'(2) : {1'b0, n};
    endfunction
endpackage

// File: rtl/kfcd_regs.sv
module kfcd_regs
    import kfcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output divs_t             div_q
);
    logic key_ok;
    assign key_ok = (wr_data[WORD_W-1 -: KEY_W] == WR_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else if (wr_en && key_ok) begin
            if (wr_sel) div_q  <= divs_t'(wr_data[INT_W+FRAC_W-1:0]);
            else        ctrl_q <= ctrl_from_word(wr_data);
        end
    end

    AST_KEY_GATE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !key_ok) |=> ($stable(ctrl_q) && $stable(div_q))); // R1

    AST_SEL_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> $stable(div_q)); // R3
endmodule

// File: rtl/kfcd_srcsel.sv
module kfcd_srcsel
    import kfcd_pkg::*;
(
    input  logic [SRC_W-1:0] sel,
    input  logic             osc_tick,
    input  logic             pll_tick,
    output logic             tick
);
    always_comb begin
        case (sel)
            SRC_CODE_OSC: tick = osc_tick;
            SRC_CODE_PLL: tick = pll_tick;
            default:      tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/kfcd_gen.sv
module kfcd_gen
    import kfcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  divs_t divs,
    input  logic  tick,
    output logic  raw,
    output logic  busy
);
    gen_state_e        st;
    logic [PER_W-1:0]  cnt;
    logic [PER_W-1:0]  per;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;
    logic [PER_W-1:0]  base;
    logic              frac_on;
    logic              hi;

    assign frac_on = (ctrl.order != '0);
    assign base    = eff_int(divs.ipart);
    assign sum     = {1'b0, acc} + {1'b0, divs.fpart};
    assign hi      = (st == GEN_RUN) && (cnt < (per >> 1));
    assign raw     = hi;
    assign busy    = (st == GEN_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= GEN_IDLE;
            cnt <= '0;
            per <= '0;
            acc <= '0;
        end else if (ctrl.kill) begin
            st  <= GEN_IDLE;
            cnt <= '0;
            acc <= '0;
        end else if (st == GEN_IDLE) begin
            if (ctrl.en) begin
                st  <= GEN_RUN;
                cnt <= '0;
                per <= base;
                acc <= frac_on ? divs.fpart : '0;
            end
        end else if (!ctrl.en && !hi) begin
            st  <= GEN_IDLE;
            cnt <= '0;
        end else if (tick) begin
            if (cnt == per - 1'b1) begin
                cnt <= '0;
                per <= base + (frac_on ? PER_W'(sum[FRAC_W]) : PER_W'(0));
                if (frac_on) acc <= sum[FRAC_W-1:0];
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_KILL_STOP: assert property (@(posedge clk) disable iff (rst)
        ctrl.kill |=> !busy); // R9

    AST_CLEAN_STOP: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(ctrl.kill)) |-> !$past(hi)); // R8

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < per)); // R5

    AST_PER_FLOOR: assert property (@(posedge clk) disable iff (rst)
        busy |-> (per >= PER_W'(2))); // R3

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(tick) && !$past(ctrl.kill)) |-> $stable(cnt)); // R4
endmodule

// File: rtl/keyed_frac_clkdiv.sv
module keyed_frac_clkdiv
    import kfcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        osc_tick,
    input  logic        pll_tick,
    output logic        clk_out,
    output logic [31:0] ctrl_rdata,
    output logic [31:0] div_rdata
);
    ctrl_t ctrl_q;
    divs_t div_q;
    logic  tick;
    logic  raw;
    logic  busy;

    kfcd_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .div_q   (div_q)
    );

    kfcd_srcsel u_src (
        .sel      (ctrl_q.src),
        .osc_tick (osc_tick),
        .pll_tick (pll_tick),
        .tick     (tick)
    );

    kfcd_gen u_gen (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl_q),
        .divs (div_q),
        .tick (tick),
        .raw  (raw),
        .busy (busy)
    );

    assign clk_out    = raw ^ ctrl_q.flip;
    assign ctrl_rdata = ctrl_to_word(ctrl_q, busy);
    assign div_rdata  = {{(WORD_W-INT_W-FRAC_W){1'b0}}, div_q};

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (clk_out == ctrl_q.flip)); // R10
endmodule

// File: tb/tb_keyed_frac_clkdiv.sv
`timescale 1ns/1ps
module tb_keyed_frac_clkdiv;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        osc_tick = 1'b0;
    logic        pll_tick = 1'b0;
    logic        clk_out;
    logic [31:0] ctrl_rdata;
    logic [31:0] div_rdata;

    keyed_frac_clkdiv dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .osc_tick(osc_tick), .pll_tick(pll_tick), .clk_out(clk_out),
        .ctrl_rdata(ctrl_rdata), .div_rdata(div_rdata)
    );

    always #2.5 clk = ~clk;

    localparam logic [31:0] KEY = 32'h5A00_0000;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    rst_done = 0;
    bit    finished = 0;
    string cur_req  = "R5";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // source pulse generation
    int osc_every = 0;
    int osc_ph = 0;
    bit pll_on = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        if (osc_every == 0) osc_tick <= 1'b0;
        else begin
            osc_ph = (osc_ph + 1) % osc_every;
            osc_tick <= (osc_ph == 0);
        end
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pll_tick <= pll_on && lfsr[0];
    end

    // behavioural reference
    int m_order = 0, m_flip = 0, m_kill = 0, m_en = 0, m_src = 0;
    int m_int = 0, m_frac = 0;
    bit m_run = 0;
    int m_pos = 0, m_len = 0, m_acc = 0;

    always @(posedge clk) begin
        bit t, h;
        int nsat, s;
        t = (m_src == 1) ? osc_tick : ((m_src == 6) ? pll_tick : 1'b0);
        h = m_run && (m_pos < m_len / 2);
        nsat = (m_int < 2) ? 2 : m_int;
        if (rst) begin
            m_order = 0; m_flip = 0; m_kill = 0; m_en = 0; m_src = 0;
            m_int = 0; m_frac = 0; m_run = 0; m_pos = 0; m_len = 0; m_acc = 0;
        end else begin
            if (m_kill != 0) begin
                m_run = 0; m_pos = 0; m_acc = 0;
            end else if (!m_run) begin
                if (m_en != 0) begin
                    m_run = 1; m_pos = 0; m_len = nsat;
                    m_acc = (m_order != 0) ? m_frac : 0;
                end
            end else if (m_en == 0 && !h) begin
                m_run = 0; m_pos = 0;
            end else if (t) begin
                if (m_pos == m_len - 1) begin
                    m_pos = 0;
                    if (m_order != 0) begin
                        s = m_acc + m_frac;
                        m_len = nsat + ((s >= 4096) ? 1 : 0);
                        m_acc = s % 4096;
                    end else m_len = nsat;
                end else m_pos++;
            end
            if (wr_en && wr_data[31:24] == 8'h5A) begin
                if (wr_sel) begin
                    m_int = int'(wr_data[23:12]); m_frac = int'(wr_data[11:0]);
                end else begin
                    m_order = int'(wr_data[10:9]); m_flip = int'(wr_data[8]);
                    m_kill = int'(wr_data[5]); m_en = int'(wr_data[4]);
                    m_src = int'(wr_data[3:0]);
                end
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_done && !finished) begin
            logic exp_out;
            logic [31:0] exp_ctrl, exp_div;
            exp_out  = (m_flip != 0) ^ (m_run && (m_pos < m_len / 2));
            exp_ctrl = (32'(m_order) << 9) | (32'(m_flip) << 8) | (32'(m_run) << 7) |
                       (32'(m_kill) << 5) | (32'(m_en) << 4) | 32'(m_src);
            exp_div  = (32'(m_int) << 12) | 32'(m_frac);
            chk(cur_req, {31'b0, clk_out}, {31'b0, exp_out});
            chk("R2", ctrl_rdata, exp_ctrl);
            chk("R3", div_rdata, exp_div);
        end
    end

    // edge monitor
    int gaps[$];
    int hiw[$];
    int cyc = 0, last_rise = -1, hi_run = 0;
    logic prev_out = 1'b0;
    always @(negedge clk) begin
        if (rst_done) begin
            cyc++;
            if (clk_out && !prev_out) begin
                if (last_rise >= 0) gaps.push_back(cyc - last_rise);
                last_rise = cyc;
            end
            if (clk_out) hi_run++;
            else if (prev_out) begin hiw.push_back(hi_run); hi_run = 0; end
            prev_out = clk_out;
        end
    end

    task automatic clear_meas();
        gaps.delete(); hiw.delete(); last_rise = -1; hi_run = 0;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] cw(input int ord, input int fl, input int kl, input int en, input int src);
        return KEY | (32'(ord) << 9) | (32'(fl) << 8) | (32'(kl) << 5) | (32'(en) << 4) | 32'(src);
    endfunction

    task automatic halt();
        wr(1'b0, KEY | 32'h20);
        wr(1'b0, KEY);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        rst_done = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", ctrl_rdata, 32'h0);
        chk("R11", div_rdata, 32'h0);
        chk("R11", {31'b0, clk_out}, 32'h0);

        // R1 wrong key ignored on both registers
        wr(1'b0, 32'hA500_0013);
        wr(1'b1, 32'h1200_5000);
        @(negedge clk);
        chk("R1", ctrl_rdata, 32'h0);
        chk("R1", div_rdata, 32'h0);

        // R2 layout, busy read-only, R10 idle level follows flip
        wr(1'b0, 32'h5AFF_FFCF);
        @(negedge clk);
        chk("R2", ctrl_rdata, 32'h0000_070F);
        chk("R10", {31'b0, clk_out}, 32'h1);
        wr(1'b0, KEY);

        // R3 divisor layout
        wr(1'b1, 32'h5AAB_C123);
        @(negedge clk);
        chk("R3", div_rdata, 32'h00AB_C123);

        // R5 integer division by 5
        osc_every = 1;
        wr(1'b1, KEY | (32'd5 << 12));
        clear_meas();
        wr(1'b0, cw(0, 0, 0, 1, 1));
        repeat (40) @(negedge clk);
        chk("R5", 32'(gaps.size() >= 5), 32'h1);
        for (int i = 0; i < 5; i++) chk("R5", 32'(gaps[i]), 32'd5);
        for (int i = 0; i < 4; i++) chk("R5", 32'(hiw[i]), 32'd2);

        // R7 new divisor used from the next period
        cur_req = "R7";
        wr(1'b1, KEY | (32'd3 << 12));
        clear_meas();
        repeat (30) @(negedge clk);
        chk("R7", 32'(gaps[gaps.size()-1]), 32'd3);

        // R3 integer 0 divides as 2
        cur_req = "R3";
        halt();
        wr(1'b1, KEY);
        clear_meas();
        wr(1'b0, cw(0, 0, 0, 1, 1));
        repeat (20) @(negedge clk);
        for (int i = 0; i < 4; i++) chk("R3", 32'(gaps[i]), 32'd2);

        // R6 first-order shaping, 3 + 0.5
        cur_req = "R6";
        halt();
        wr(1'b1, KEY | (32'd3 << 12) | 32'h800);
        clear_meas();
        wr(1'b0, cw(1, 0, 0, 1, 1));
        repeat (30) @(negedge clk);
        chk("R6", 32'(gaps[0]), 32'd3);
        chk("R6", 32'(gaps[1]), 32'd4);
        chk("R6", 32'(gaps[2]), 32'd3);
        chk("R6", 32'(gaps[3]), 32'd4);

        // R12 order 2 acts as order 1
        cur_req = "R12";
        halt();
        clear_meas();
        wr(1'b0, cw(2, 0, 0, 1, 1));
        repeat (30) @(negedge clk);
        chk("R12", 32'(gaps[0]), 32'd3);
        chk("R12", 32'(gaps[1]), 32'd4);
        chk("R12", 32'(gaps[2]), 32'd3);

        // R10 flipped output while running
        cur_req = "R10";
        halt();
        wr(1'b1, KEY | (32'd7 << 12) | 32'h555);
        wr(1'b0, cw(3, 1, 0, 1, 1));
        repeat (100) @(negedge clk);

        // R4 pll source, then a silent code holds the output
        cur_req = "R4";
        halt();
        pll_on = 1;
        wr(1'b1, KEY | (32'd4 << 12) | 32'h300);
        wr(1'b0, cw(1, 0, 0, 1, 6));
        repeat (300) @(negedge clk);
        wr(1'b0, cw(1, 0, 0, 1, 2));
        @(negedge clk);
        begin
            logic snap;
            int changes;
            snap = clk_out;
            changes = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (clk_out !== snap) changes++;
            end
            chk("R4", 32'(changes), 32'd0);
            chk("R4", {31'b0, ctrl_rdata[7]}, 32'h1);
        end

        // R8 graceful stop during the high phase
        cur_req = "R8";
        halt();
        osc_every = 4;
        wr(1'b1, KEY | (32'd8 << 12));
        wr(1'b0, cw(0, 0, 0, 1, 1));
        for (int i = 0; i < 20 && clk_out == 1'b0; i++) @(negedge clk);
        wr(1'b0, cw(0, 0, 0, 0, 1));
        chk("R8", {31'b0, ctrl_rdata[7]}, 32'h1);
        for (int i = 0; i < 100 && ctrl_rdata[7] == 1'b1; i++) @(negedge clk);
        chk("R8", {31'b0, ctrl_rdata[7]}, 32'h0);
        chk("R8", {31'b0, clk_out}, 32'h0);

        // R9 kill ends a stop that a silent source cannot finish
        cur_req = "R9";
        halt();
        wr(1'b0, cw(0, 0, 0, 1, 0));
        repeat (3) @(negedge clk);
        chk("R5", {31'b0, clk_out}, 32'h1);
        wr(1'b0, cw(0, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        chk("R8", {31'b0, ctrl_rdata[7]}, 32'h1);
        wr(1'b0, cw(0, 0, 1, 0, 0));
        @(negedge clk);
        chk("R9", {31'b0, ctrl_rdata[7]}, 32'h0);
        chk("R9", {31'b0, clk_out}, 32'h0);
        osc_every = 1;
        wr(1'b0, cw(0, 0, 1, 1, 1));
        repeat (10) @(negedge clk);
        chk("R9", {31'b0, ctrl_rdata[7]}, 32'h0);
        wr(1'b0, cw(0, 0, 0, 1, 1));
        repeat (3) @(negedge clk);
        chk("R9", {31'b0, ctrl_rdata[7]}, 32'h1);

        // R7 writes and kills falling on arbitrary edges
        cur_req = "R7";
        for (int i = 0; i < 200; i++) begin
            osc_every = (i % 3 == 0) ? 1 : 0;
            wr(1'b1, KEY | (32'(2 + i % 6) << 12) | 32'((i * 337) % 4096));
            if (i % 17 == 5) begin
                wr(1'b0, cw(i % 4, 0, 1, 1, 6));
                wr(1'b0, cw(i % 4, 0, 0, 1, (i % 3 == 0) ? 1 : 6));
            end
            repeat (i % 7) @(negedge clk);
        end
        repeat (20) @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end
endmodule